// File: doc/BRIEF.md
# Debug Emulation Mode Controller

This block tracks whether a processor core is in the emulation state used for non-intrusive debugging. Three trigger paths can start that state. The first is a forced-emulation control bit, which is looked at only on the strobe that marks the start of reset exception processing. The bit may be set earlier, while the core is halted. The second is any debug interrupt. The third is a trace-enable bit, which is sampled on the strobe that marks the start of trace exception processing. A return-from-exception strobe ends the state. If a breakpoint is still armed after the return, the debug interrupt it raises simply re-enters the state.

While the state is active, the block forces every interrupt request level to zero, including the non-maskable level 7. When the map control bit is also set, it asserts a bypass flag that turns off caching and on-chip SRAM. It also retags every memory access passing through it: transfer type 2, with transfer modifier 5 for data and 6 for instruction fetches. Retagging starts in the cycle after the trigger, so the stack frame writes and the vector fetch of the entry exception are covered. A 4-bit status port shows 0xD for one cycle on entry, 0x7 for one cycle on exit and 0x0 at all other times.

The access path is a valid/ready stream. The block adds no storage and no stall to it. An access transfers on a cycle when both `acc_in_valid` and `acc_out_ready` are 1. Back-pressure from downstream reaches `acc_in_ready` unchanged in the same cycle. Only the type and modifier fields are rewritten.

Top module: `emu_mode_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the mode. In the cycle after `rst`, `emu_active`=0, `pst`=0x0 and `emu_cause`=0, even if the mode was active.
- R2: When inactive, `rst_exc_start`=1 with `force_emu`=1 enters the mode. `force_emu` without `rst_exc_start` has no effect.
- R3: When inactive, `dbg_irq`=1 enters the mode.
- R4: When inactive, `trace_exc_start`=1 with `trace_en`=1 enters the mode. Either input alone has no effect.
- R5: Triggers arriving in the same cycle record one entry and produce one 0xD. `emu_cause` holds the winner until exit: 1 = forced bit, 2 = debug interrupt, 3 = trace. The forced bit has the highest priority and trace the lowest.
- R6: Entry sets `emu_active` and shows `pst`=0xD in the cycle after the trigger is sampled. `pst` returns to 0x0 in the following cycle while the mode stays active.
- R7: `rte_done` while active clears `emu_active` and `emu_cause` and shows `pst`=0x7 in the next cycle, for one cycle only. `rte_done` while inactive leaves `pst` at 0x0.
- R8: While active, entry triggers are ignored: no second 0xD, and `emu_cause` is unchanged. This also holds in a cycle where `rte_done` arrives, which still exits.
- R9: While `emu_active`=1, `irq_gated` is 0 for every `irq_req` value, including 7. While inactive, `irq_gated` equals `irq_req`.
- R10: While `emu_active`=1 and `map_en`=1, `mem_bypass`=1, `acc_out_tt`=2, and `acc_out_tm` is 5 when `acc_in_fetch`=0 and 6 when it is 1. Otherwise `mem_bypass`=0 and the type and modifier fields pass through unchanged.
- R11: Retagging applies to accesses in the first cycle after the trigger.
- R12: `acc_out_valid` equals `acc_in_valid` and `acc_in_ready` equals `acc_out_ready` in the same cycle. `acc_out_fetch` equals `acc_in_fetch`.
- R13: A debug interrupt arriving in the cycle right after an exit re-enters the mode with a fresh 0xD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_exc_start | input | 1 | Strobe: reset exception processing begins |
| force_emu | input | 1 | Forced-emulation control bit |
| dbg_irq | input | 1 | Debug interrupt strobe |
| trace_exc_start | input | 1 | Strobe: trace exception processing begins |
| trace_en | input | 1 | Trace-enable control bit |
| rte_done | input | 1 | Return-from-exception strobe |
| map_en | input | 1 | Remap-to-debug-space control bit |
| irq_req | input | 3 | Incoming interrupt level |
| irq_gated | output | 3 | Interrupt level seen by the core |
| acc_in_valid | input | 1 | Access stream valid, upstream |
| acc_in_ready | output | 1 | Access stream ready, upstream |
| acc_in_fetch | input | 1 | Access is an instruction fetch |
| acc_in_tt | input | 2 | Upstream transfer type |
| acc_in_tm | input | 3 | Upstream transfer modifier |
| acc_out_valid | output | 1 | Access stream valid, downstream |
| acc_out_ready | input | 1 | Access stream ready, downstream |
| acc_out_fetch | output | 1 | Fetch flag, downstream |
| acc_out_tt | output | 2 | Transfer type after remap |
| acc_out_tm | output | 3 | Transfer modifier after remap |
| mem_bypass | output | 1 | Disable caching and on-chip SRAM |
| emu_active | output | 1 | Emulation mode flag |
| emu_cause | output | 2 | Entry cause code |
| pst | output | 4 | Processor status code |

## Verification
`emu_active`, `emu_cause` and `pst` are registered, so they respond one clock edge after the cycle in which a trigger, `rte_done` or `rst` is sampled. Interrupt gating, remap tags, bypass and handshake are combinational. They follow `emu_active` and the current inputs in the same cycle. The bench drives each stimulus on a falling edge and samples one time unit after the next rising edge. At that point the registered results have updated and the combinational inputs are still the ones just applied. A `pst` pulse is checked both in its single cycle and in the cycle after.

// File: rtl/emu_pkg.sv
package emu_pkg;
  localparam int PST_W  = 4;
  localparam int N_SRC  = 3;
  localparam int CAUSE_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_FORCE = 2'd1,
    CAUSE_DEBUG = 2'd2,
    CAUSE_TRACE = 2'd3
  } cause_e;

  localparam logic [PST_W-1:0] PST_IDLE  = 4'h0;
  localparam logic [PST_W-1:0] PST_ENTER = 4'hD;
  localparam logic [PST_W-1:0] PST_EXIT  = 4'h7;
endpackage

// File: rtl/emu_entry_arb.sv
module emu_entry_arb #(
  parameter int NSRC = 3,
  localparam int IW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  output logic [NSRC-1:0] grant,
  output logic            any,
  output logic [IW-1:0]   idx
);
  // lowest index wins
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_pri
      if (g == 0) begin : g_first
        assign grant[g] = req[g];
      end else begin : g_rest
        assign grant[g] = req[g] & ~|req[g-1:0];
      end
    end
  endgenerate

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i + 1);
    end
  end

  // R5: one winner only
  p_single_grant_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  p_grant_when_req_r5: assert property (@(posedge clk) disable iff (rst)
    any |-> (grant[idx - 1'b1]));
endmodule

// File: rtl/emu_mode_fsm.sv
module emu_mode_fsm
  import emu_pkg::*;
#(
  parameter int PW = PST_W,
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          entry_any,
  input  logic [CW-1:0] entry_idx,
  input  logic          rte,
  output logic          emu_q,
  output logic [PW-1:0] pst_q,
  output logic [CW-1:0] cause_q
);
  logic enter, leave;
  assign enter = !emu_q && entry_any;
  assign leave = emu_q && rte;

  always_ff @(posedge clk) begin
    if (rst) begin
      emu_q   <= 1'b0;
      pst_q   <= PST_IDLE;
      cause_q <= CAUSE_NONE;
    end else if (enter) begin
      emu_q   <= 1'b1;
      pst_q   <= PST_ENTER;
      cause_q <= entry_idx;
    end else if (leave) begin
      emu_q   <= 1'b0;
      pst_q   <= PST_EXIT;
      cause_q <= CAUSE_NONE;
    end else begin
      pst_q   <= PST_IDLE;
    end
  end

  p_enter_code_r6: assert property (@(posedge clk) disable iff (rst)
    (!emu_q && entry_any) |=> (emu_q && pst_q == PST_ENTER));
  p_exit_code_r7: assert property (@(posedge clk) disable iff (rst)
    (emu_q && rte) |=> (!emu_q && pst_q == PST_EXIT && cause_q == CAUSE_NONE));
  p_hold_active_r8: assert property (@(posedge clk) disable iff (rst)
    (emu_q && !rte) |=> (emu_q && $stable(cause_q) && pst_q == PST_IDLE));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!emu_q && !entry_any) |=> (!emu_q && pst_q == PST_IDLE));
endmodule

// File: rtl/emu_irq_gate.sv
module emu_irq_gate #(
  parameter int IRQ_W = 3
) (
  input  logic             active,
  input  logic [IRQ_W-1:0] irq_in,
  output logic [IRQ_W-1:0] irq_out
);
  assign irq_out = active ? '0 : irq_in;
endmodule

// File: rtl/emu_acc_remap.sv
module emu_acc_remap #(
  parameter int TT_W = 2,
  parameter int TM_W = 3
) (
  input  logic            active,
  input  logic            map,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_fetch,
  input  logic [TT_W-1:0] in_tt,
  input  logic [TM_W-1:0] in_tm,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_fetch,
  output logic [TT_W-1:0] out_tt,
  output logic [TM_W-1:0] out_tm,
  output logic            bypass
);
  localparam logic [TT_W-1:0] TT_DBG   = TT_W'(2);
  localparam logic [TM_W-1:0] TM_DATA  = TM_W'(5);
  localparam logic [TM_W-1:0] TM_FETCH = TM_W'(6);

  logic remap;
  assign remap     = active && map;
  assign bypass    = remap;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_fetch = in_fetch;

  always_comb begin
    out_tt = in_tt;
    out_tm = in_tm;
    if (remap) begin
      out_tt = TT_DBG;
      out_tm = in_fetch ? TM_FETCH : TM_DATA;
    end
  end
endmodule

// File: rtl/emu_mode_ctrl.sv
module emu_mode_ctrl
  import emu_pkg::*;
#(
  parameter int IRQ_W = 3,
  parameter int TT_W  = 2,
  parameter int TM_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_exc_start,
  input  logic             force_emu,
  input  logic             dbg_irq,
  input  logic             trace_exc_start,
  input  logic             trace_en,
  input  logic             rte_done,
  input  logic             map_en,
  input  logic [IRQ_W-1:0] irq_req,
  output logic [IRQ_W-1:0] irq_gated,
  input  logic             acc_in_valid,
  output logic             acc_in_ready,
  input  logic             acc_in_fetch,
  input  logic [TT_W-1:0]  acc_in_tt,
  input  logic [TM_W-1:0]  acc_in_tm,
  output logic             acc_out_valid,
  input  logic             acc_out_ready,
  output logic             acc_out_fetch,
  output logic [TT_W-1:0]  acc_out_tt,
  output logic [TM_W-1:0]  acc_out_tm,
  output logic             mem_bypass,
  output logic             emu_active,
  output logic [CAUSE_W-1:0] emu_cause,
  output logic [PST_W-1:0] pst
);
  logic [N_SRC-1:0]   req, grant;
  logic               any;
  logic [CAUSE_W-1:0] idx;

  // priority order: forced bit, debug interrupt, trace
  assign req[0] = rst_exc_start && force_emu;
  assign req[1] = dbg_irq;
  assign req[2] = trace_exc_start && trace_en;

  emu_entry_arb #(.NSRC(N_SRC)) arb_i (
    .clk(clk), .rst(rst), .req(req), .grant(grant), .any(any), .idx(idx)
  );

  emu_mode_fsm #(.PW(PST_W), .CW(CAUSE_W)) fsm_i (
    .clk(clk), .rst(rst), .entry_any(any), .entry_idx(idx), .rte(rte_done),
    .emu_q(emu_active), .pst_q(pst), .cause_q(emu_cause)
  );

  emu_irq_gate #(.IRQ_W(IRQ_W)) gate_i (
    .active(emu_active), .irq_in(irq_req), .irq_out(irq_gated)
  );

  emu_acc_remap #(.TT_W(TT_W), .TM_W(TM_W)) remap_i (
    .active(emu_active), .map(map_en),
    .in_valid(acc_in_valid), .in_ready(acc_in_ready), .in_fetch(acc_in_fetch),
    .in_tt(acc_in_tt), .in_tm(acc_in_tm),
    .out_valid(acc_out_valid), .out_ready(acc_out_ready), .out_fetch(acc_out_fetch),
    .out_tt(acc_out_tt), .out_tm(acc_out_tm), .bypass(mem_bypass)
  );

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    emu_active |-> (irq_gated == '0));
  p_irq_pass_r9: assert property (@(posedge clk) disable iff (rst)
    !emu_active |-> (irq_gated == irq_req));
  p_remap_tag_r10: assert property (@(posedge clk) disable iff (rst)
    (emu_active && map_en && acc_out_valid) |->
      (acc_out_tt == TT_W'(2) && acc_out_tm == (acc_in_fetch ? TM_W'(6) : TM_W'(5))));
  p_no_bypass_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !emu_active |-> !mem_bypass);
  p_cause_valid_r5: assert property (@(posedge clk) disable iff (rst)
    emu_active |-> (emu_cause != CAUSE_NONE));
endmodule

// File: tb/emu_mode_ctrl_tb_top.sv
module emu_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst, rst_exc_start, force_emu, dbg_irq, trace_exc_start, trace_en, rte_done, map_en;
  logic [2:0] irq_req, irq_gated;
  logic acc_in_valid, acc_in_ready, acc_in_fetch, acc_out_valid, acc_out_ready, acc_out_fetch;
  logic [1:0] acc_in_tt, acc_out_tt, emu_cause;
  logic [2:0] acc_in_tm, acc_out_tm;
  logic mem_bypass, emu_active;
  logic [3:0] pst;

  emu_mode_ctrl dut_i (
    .clk(clk), .rst(rst), .rst_exc_start(rst_exc_start), .force_emu(force_emu),
    .dbg_irq(dbg_irq), .trace_exc_start(trace_exc_start), .trace_en(trace_en),
    .rte_done(rte_done), .map_en(map_en), .irq_req(irq_req), .irq_gated(irq_gated),
    .acc_in_valid(acc_in_valid), .acc_in_ready(acc_in_ready), .acc_in_fetch(acc_in_fetch),
    .acc_in_tt(acc_in_tt), .acc_in_tm(acc_in_tm), .acc_out_valid(acc_out_valid),
    .acc_out_ready(acc_out_ready), .acc_out_fetch(acc_out_fetch), .acc_out_tt(acc_out_tt),
    .acc_out_tm(acc_out_tm), .mem_bypass(mem_bypass), .emu_active(emu_active),
    .emu_cause(emu_cause), .pst(pst)
  );

  // {rst,rxs,force,dbg,tstart,tbit,rte,irq[2:0],exp_act,exp_pst[3:0],exp_cause[1:0],req[3:0]}
  function automatic logic [20:0] mk(input logic r, x, f, d, ts, tb, e,
                                     input logic [2:0] q, input logic a,
                                     input logic [3:0] p, input logic [1:0] c,
                                     input logic [3:0] rq);
    return {r, x, f, d, ts, tb, e, q, a, p, c, rq};
  endfunction

  localparam logic [20:0] TBL [NV] = '{
    mk(1,0,0,0,0,0,0, 3'd5, 0, 4'h0, 2'd0, 4'd1),  // R1 reset state
    mk(0,0,0,0,0,0,0, 3'd7, 0, 4'h0, 2'd0, 4'd9),  // R9 pass through level 7
    mk(0,0,1,0,0,0,0, 3'd2, 0, 4'h0, 2'd0, 4'd2),  // R2 forced bit alone
    mk(0,1,1,0,0,0,0, 3'd7, 1, 4'hD, 2'd1, 4'd2),  // R2 R6 forced entry, level 7 masked
    mk(0,0,0,0,0,0,0, 3'd7, 1, 4'h0, 2'd1, 4'd6),  // R6 code lasts one cycle
    mk(0,0,0,1,0,0,0, 3'd4, 1, 4'h0, 2'd1, 4'd8),  // R8 trigger while active
    mk(0,0,0,0,0,0,1, 3'd3, 0, 4'h7, 2'd0, 4'd7),  // R7 exit
    mk(0,0,0,0,0,0,0, 3'd3, 0, 4'h0, 2'd0, 4'd7),  // R7 exit code one cycle
    mk(0,0,0,0,0,0,1, 3'd1, 0, 4'h0, 2'd0, 4'd7),  // R7 rte while inactive
    mk(0,0,0,1,1,1,0, 3'd0, 1, 4'hD, 2'd2, 4'd5),  // R5 R3 debug beats trace
    mk(0,0,0,0,0,0,1, 3'd0, 0, 4'h7, 2'd0, 4'd7),  // R7
    mk(0,0,0,1,0,0,0, 3'd6, 1, 4'hD, 2'd2, 4'd13), // R13 re-entry right after exit
    mk(0,0,0,1,0,0,1, 3'd6, 0, 4'h7, 2'd0, 4'd8),  // R8 rte plus trigger: exits
    mk(0,0,0,0,1,0,0, 3'd6, 0, 4'h0, 2'd0, 4'd4),  // R4 trace start alone
    mk(0,0,0,0,0,1,0, 3'd6, 0, 4'h0, 2'd0, 4'd4),  // R4 trace bit alone
    mk(0,0,0,0,1,1,0, 3'd6, 1, 4'hD, 2'd3, 4'd4),  // R4 trace entry
    mk(1,0,0,0,0,0,0, 3'd2, 0, 4'h0, 2'd0, 4'd1),  // R1 reset clears active mode
    mk(0,1,1,1,1,1,0, 3'd2, 1, 4'hD, 2'd1, 4'd5),  // R5 all three: forced wins
    mk(1,0,0,0,0,0,0, 3'd2, 0, 4'h0, 2'd0, 4'd1)   // R1
  };

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rst = 0; rst_exc_start = 0; force_emu = 0; dbg_irq = 0;
    trace_exc_start = 0; trace_en = 0; rte_done = 0;
  endtask

  initial begin
    idle_inputs();
    rst = 1; map_en = 0; irq_req = 0;
    acc_in_valid = 0; acc_out_ready = 0; acc_in_fetch = 0; acc_in_tt = 0; acc_in_tm = 0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      string tag;
      v = TBL[i];
      {rst, rst_exc_start, force_emu, dbg_irq, trace_exc_start, trace_en, rte_done} = v[20:14];
      irq_req = v[13:11];
      @(posedge clk); #1;
      tag = $sformatf("R%0d row%0d", v[3:0], i);
      check({tag, " active"}, emu_active, v[10]);
      check({tag, " pst"}, pst, v[9:6]);
      check({tag, " cause"}, emu_cause, v[5:4]);
      check({tag, " irq"}, irq_gated, v[10] ? 3'd0 : v[13:11]);
      @(negedge clk);
    end

    // R10 pass-through while inactive, map set
    idle_inputs();
    map_en = 1; acc_in_valid = 1; acc_out_ready = 1; acc_in_fetch = 0;
    acc_in_tt = 2'd1; acc_in_tm = 3'd1;
    #1;
    check("R10 idle tt", acc_out_tt, 2'd1);
    check("R10 idle tm", acc_out_tm, 3'd1);
    check("R10 idle bypass", mem_bypass, 1'b0);
    // R11 first cycle after debug trigger already retagged
    dbg_irq = 1;
    @(posedge clk); #1;
    check("R11 tt", acc_out_tt, 2'd2);
    check("R11 tm data", acc_out_tm, 3'd5);
    check("R10 bypass", mem_bypass, 1'b1);
    @(negedge clk);
    dbg_irq = 0; acc_in_fetch = 1;
    #1;
    check("R10 tm fetch", acc_out_tm, 3'd6);
    check("R12 fetch flag", acc_out_fetch, 1'b1);
    map_en = 0;
    #1;
    check("R10 map off tt", acc_out_tt, 2'd1);
    check("R10 map off tm", acc_out_tm, 3'd1);
    check("R10 map off bypass", mem_bypass, 1'b0);
    acc_out_ready = 0;
    #1;
    check("R12 ready back-pressure", acc_in_ready, 1'b0);
    check("R12 valid", acc_out_valid, 1'b1);
    acc_in_valid = 0; acc_out_ready = 1;
    #1;
    check("R12 valid low", acc_out_valid, 1'b0);
    check("R12 ready", acc_in_ready, 1'b1);
    // R3 active after debug entry; exit then confirm map does nothing
    check("R3 active", emu_active, 1'b1);
    @(negedge clk);
    rte_done = 1; map_en = 1; acc_in_valid = 1; acc_in_fetch = 0;
    @(posedge clk); #1;
    check("R7 exit pst", pst, 4'h7);
    check("R10 after exit tt", acc_out_tt, 2'd1);
    check("R10 after exit bypass", mem_bypass, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule